// File: doc/BRIEF.md
# Write Unlock Sequence Gate

This block sits between a write-strobe bus and a page write controller. Every write operation has to begin with a fixed three-write key sequence. Each key write must carry a specific address and data pair. The gate consumes the key writes instead of passing them on. Once all three keys have matched, it forwards the writes that follow to the page controller as one page load. It keeps forwarding until the bus stays quiet for longer than the allowed inter-byte gap. At that point it signals that the load has closed and waits for a new key sequence.

A write that arrives without a valid key sequence is not forwarded. The gate reports it as rejected, so that the device can still run its busy period without changing any stored byte. After reset, the gate ignores every write for a programmable number of cycles before it starts to evaluate them.

Top module: `unlock_gate`

## Requirements
- R1: While reset is asserted, and on the first edge after it, `fwdStb`, `cmdStb`, `rejStb` and `loadEnd` are all low.
- R2: On the first HOLD_CYCLES rising edges after reset is released, a write produces no strobe at all and does not advance the sequence. A write on edge HOLD_CYCLES+1 is evaluated.
- R3: The key pairs are accepted only in this order: KEY0 (default address 0x5555, data 0xAA), then KEY1 (0x2AAA, 0x55), then KEY2 (0x5555, 0xA0). Each matching key write raises `cmdStb` for one cycle, on the edge that samples it, and is never forwarded.
- R4: After KEY2, every following write raises `fwdStb` on the edge that samples it, with `fwdAddr` and `fwdData` equal to that write's address and data. This includes writes whose address or data equal a key pair.
- R5: A write that is evaluated as a key step but does not match that step's pair raises `rejStb` for one cycle and returns the gate to the first step. A write at KEY1 or KEY2 with the wrong pair therefore also counts as rejected.
- R6: A write continues a sequence or load only if its strobe arrives at most GAP_LIMIT cycles after the previous evaluated write. A later write is evaluated as the first key step.
- R7: When the gap limit runs out in an open load that has forwarded at least one byte, `loadEnd` pulses for one cycle on the edge GAP_LIMIT+1 cycles after the last forwarded write. A load that has forwarded no bytes closes without `loadEnd`.
- R8: After a load closes, a data write without a fresh key sequence is rejected.
- R9: At most one of `fwdStb`, `cmdStb` and `rejStb` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrStb | input | 1 | One-cycle write strobe |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data |
| fwdStb | output | 1 | Forwarded page-load write |
| fwdAddr | output | ADDR_W | Address of the forwarded write |
| fwdData | output | DATA_W | Data of the forwarded write |
| cmdStb | output | 1 | A key write was consumed |
| rejStb | output | 1 | An unprotected write was rejected |
| loadEnd | output | 1 | The open page load has closed |

## Verification
Each strobe that answers a write (`cmdStb`, `fwdStb` with its address and data, `rejStb`) is registered once. It is therefore due just after the same clock edge that samples the write, which is one cycle after the bench presents the write. `loadEnd` is due GAP_LIMIT+1 edges after the last forwarded write. The hold window ends on edge HOLD_CYCLES+1 after reset release. The bench drives inputs just after an edge and samples all outputs one time unit after the next edge. Its model advances once per edge, so every expected value lines up with exactly that edge, including writes placed at exactly GAP_LIMIT and GAP_LIMIT+1 cycles.

// File: rtl/unlock_gate_pkg.sv
`timescale 1ns/1ps
package unlock_gate_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_KEY1 = 2'd1,
    ST_KEY2 = 2'd2,
    ST_OPEN = 2'd3
  } gate_state_e;

  typedef struct packed {
    logic fwd;
    logic cmd;
    logic rej;
    logic loadEnd;
  } gate_stb_t;

endpackage

// File: rtl/unlock_gate_ctrl.sv
`timescale 1ns/1ps
module unlock_gate_ctrl
  import unlock_gate_pkg::*;
#(
  parameter int GAP_LIMIT   = 32,
  parameter int HOLD_CYCLES = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrStb,
  input  logic [2:0] keyHit,
  output gate_stb_t stb
);

  localparam int GAP_W  = $clog2(GAP_LIMIT + 1);
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);

  logic [HOLD_W-1:0] holdCnt;
  logic [GAP_W-1:0]  gapCnt;
  gate_state_e       state, stateNxt, effState;
  logic              hasData, hasDataNxt;
  logic              holding, accept, expired;

  always_comb begin
    holding    = (holdCnt != '0);
    accept     = wrStb && !holding;
    expired    = (state != ST_IDLE) && (gapCnt == GAP_W'(GAP_LIMIT));
    effState   = expired ? ST_IDLE : state;
    stb        = '0;
    stb.loadEnd = expired && (state == ST_OPEN) && hasData;
    stateNxt   = effState;
    hasDataNxt = expired ? 1'b0 : hasData;
    if (accept) begin
      unique case (effState)
        ST_IDLE: begin
          stb.cmd  = keyHit[0];
          stb.rej  = !keyHit[0];
          stateNxt = keyHit[0] ? ST_KEY1 : ST_IDLE;
        end
        ST_KEY1: begin
          stb.cmd  = keyHit[1];
          stb.rej  = !keyHit[1];
          stateNxt = keyHit[1] ? ST_KEY2 : ST_IDLE;
        end
        ST_KEY2: begin
          stb.cmd    = keyHit[2];
          stb.rej    = !keyHit[2];
          stateNxt   = keyHit[2] ? ST_OPEN : ST_IDLE;
          hasDataNxt = 1'b0;
        end
        default: begin
          stb.fwd    = 1'b1;
          hasDataNxt = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= HOLD_W'(HOLD_CYCLES);
      gapCnt  <= '0;
      state   <= ST_IDLE;
      hasData <= 1'b0;
    end else begin
      if (holding) holdCnt <= holdCnt - 1'b1;
      if (accept) gapCnt <= '0;
      else if (gapCnt != GAP_W'(GAP_LIMIT)) gapCnt <= gapCnt + 1'b1;
      state   <= stateNxt;
      hasData <= hasDataNxt;
    end
  end

  // R3: the last key step is reachable only through the middle one
  a_r3_key_order: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_KEY2) |-> ($past(state) == ST_KEY1 || $past(state) == ST_KEY2));

  // R6: the quiet-time counter never passes its limit
  a_r6_gap_bound: assert property (@(posedge clk) disable iff (!rstN)
    gapCnt <= GAP_W'(GAP_LIMIT));

  // R2: nothing is accepted while the power-on hold runs
  a_r2_hold_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (holdCnt != '0) |=> (state == ST_IDLE));

endmodule

// File: rtl/unlock_gate_dp.sv
`timescale 1ns/1ps
module unlock_gate_dp
  import unlock_gate_pkg::*;
#(
  parameter int                ADDR_W    = 15,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] KEY0_ADDR = 15'h5555,
  parameter logic [DATA_W-1:0] KEY0_DATA = 8'hAA,
  parameter logic [ADDR_W-1:0] KEY1_ADDR = 15'h2AAA,
  parameter logic [DATA_W-1:0] KEY1_DATA = 8'h55,
  parameter logic [ADDR_W-1:0] KEY2_ADDR = 15'h5555,
  parameter logic [DATA_W-1:0] KEY2_DATA = 8'hA0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  gate_stb_t         stb,
  output logic [2:0]        keyHit,
  output logic              fwdStb,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic [DATA_W-1:0] fwdData,
  output logic              cmdStb,
  output logic              rejStb,
  output logic              loadEnd
);

  localparam int NKEY = 3;
  localparam logic [NKEY*ADDR_W-1:0] keyAddrs = {KEY2_ADDR, KEY1_ADDR, KEY0_ADDR};
  localparam logic [NKEY*DATA_W-1:0] keyDatas = {KEY2_DATA, KEY1_DATA, KEY0_DATA};

  for (genvar k = 0; k < NKEY; k++) begin : g_key
    assign keyHit[k] = (wrAddr == keyAddrs[k*ADDR_W +: ADDR_W]) &&
                       (wrData == keyDatas[k*DATA_W +: DATA_W]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fwdStb  <= 1'b0;
      cmdStb  <= 1'b0;
      rejStb  <= 1'b0;
      loadEnd <= 1'b0;
      fwdAddr <= '0;
      fwdData <= '0;
    end else begin
      fwdStb  <= stb.fwd;
      cmdStb  <= stb.cmd;
      rejStb  <= stb.rej;
      loadEnd <= stb.loadEnd;
      if (stb.fwd) begin
        fwdAddr <= wrAddr;
        fwdData <= wrData;
      end
    end
  end

  // R9: one write answers with at most one kind of strobe
  a_r9_one_kind: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({fwdStb, cmdStb, rejStb}));

  // R4: a forwarded write carries the bus values of the sampled write
  a_r4_fwd_echo: assert property (@(posedge clk) disable iff (!rstN)
    wrStb && stb.fwd |=> fwdStb && fwdAddr == $past(wrAddr) && fwdData == $past(wrData));

  // R5: a rejection always answers a real write
  a_r5_rej_cause: assert property (@(posedge clk) disable iff (!rstN)
    stb.rej |-> wrStb);

  // R7: the close marker is a single-cycle pulse
  a_r7_end_pulse: assert property (@(posedge clk) disable iff (!rstN)
    loadEnd |=> !loadEnd);

endmodule

// File: rtl/unlock_gate.sv
`timescale 1ns/1ps
module unlock_gate
  import unlock_gate_pkg::*;
#(
  parameter int                ADDR_W      = 15,
  parameter int                DATA_W      = 8,
  parameter logic [ADDR_W-1:0] KEY0_ADDR   = 15'h5555,
  parameter logic [DATA_W-1:0] KEY0_DATA   = 8'hAA,
  parameter logic [ADDR_W-1:0] KEY1_ADDR   = 15'h2AAA,
  parameter logic [DATA_W-1:0] KEY1_DATA   = 8'h55,
  parameter logic [ADDR_W-1:0] KEY2_ADDR   = 15'h5555,
  parameter logic [DATA_W-1:0] KEY2_DATA   = 8'hA0,
  parameter int                GAP_LIMIT   = 32,
  parameter int                HOLD_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              fwdStb,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic [DATA_W-1:0] fwdData,
  output logic              cmdStb,
  output logic              rejStb,
  output logic              loadEnd
);

  gate_stb_t  stb;
  logic [2:0] keyHit;

  unlock_gate_ctrl #(
    .GAP_LIMIT  (GAP_LIMIT),
    .HOLD_CYCLES(HOLD_CYCLES)
  ) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .wrStb (wrStb),
    .keyHit(keyHit),
    .stb   (stb)
  );

  unlock_gate_dp #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .KEY0_ADDR(KEY0_ADDR),
    .KEY0_DATA(KEY0_DATA),
    .KEY1_ADDR(KEY1_ADDR),
    .KEY1_DATA(KEY1_DATA),
    .KEY2_ADDR(KEY2_ADDR),
    .KEY2_DATA(KEY2_DATA)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .wrStb  (wrStb),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .stb    (stb),
    .keyHit (keyHit),
    .fwdStb (fwdStb),
    .fwdAddr(fwdAddr),
    .fwdData(fwdData),
    .cmdStb (cmdStb),
    .rejStb (rejStb),
    .loadEnd(loadEnd)
  );

endmodule

// File: tb/unlock_gate_tb_top.sv
`timescale 1ns/1ps
module unlock_gate_tb_top;

  localparam int GAP  = 6;
  localparam int HOLD = 10;
  localparam logic [14:0] KA [3] = '{15'h5555, 15'h2AAA, 15'h5555};
  localparam logic [7:0]  KD [3] = '{8'hAA, 8'h55, 8'hA0};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStb = 1'b0;
  logic [14:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        fwdStb, cmdStb, rejStb, loadEnd;
  logic [14:0] fwdAddr;
  logic [7:0]  fwdData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // bench model of the sequence
  int mHold, mStep, mGap;
  bit mHas;

  always #2.5 clk = ~clk;

  unlock_gate #(.GAP_LIMIT(GAP), .HOLD_CYCLES(HOLD)) dut_i (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrAddr(wrAddr), .wrData(wrData),
    .fwdStb(fwdStb), .fwdAddr(fwdAddr), .fwdData(fwdData),
    .cmdStb(cmdStb), .rejStb(rejStb), .loadEnd(loadEnd)
  );

  function automatic bit keyMatch(int idx, logic [14:0] a, logic [7:0] d);
    return (a == KA[idx]) && (d == KD[idx]);
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // present one cycle of bus activity, advance the model, compare after the edge
  task automatic step(bit s, logic [14:0] a, logic [7:0] d, string tagIn);
    bit eF, eC, eR, eE, expd;
    string tag;
    eF = 0; eC = 0; eR = 0; eE = 0; expd = 0;
    tag = "R6";
    wrStb = s; wrAddr = a; wrData = d;
    if (mHold > 0) begin
      mHold--;
      if (mGap < GAP) mGap++;
      tag = "R2";
    end else begin
      expd = (mStep != 0) && (mGap == GAP);
      if (expd) begin
        eE = (mStep == 3) && mHas;
        mStep = 0;
        mHas = 0;
      end
      if (s) begin
        mGap = 0;
        if (mStep == 3) begin
          eF = 1; mHas = 1;
        end else if (keyMatch(mStep, a, d)) begin
          eC = 1;
          mStep++;
          if (mStep == 3) mHas = 0;
        end else begin
          eR = 1;
          mStep = 0;
        end
      end else if (mGap < GAP) mGap++;
      if (eE) tag = "R7";
      else if (expd && s) tag = "R6";
      else if (eF) tag = "R4";
      else if (eC) tag = "R3";
      else if (eR) tag = "R5";
    end
    if (tagIn != "") tag = tagIn;
    tick();
    wrStb = 1'b0;
    nChecks++;
    if (fwdStb !== eF || cmdStb !== eC || rejStb !== eR || loadEnd !== eE ||
        (eF && (fwdAddr !== a || fwdData !== d)) ||
        ((fwdStb + cmdStb + rejStb) > 1)) begin
      nFails++;
      $display("FAIL %s (R9 onehot incl.): got fwd=%0b cmd=%0b rej=%0b end=%0b addr=%h data=%h, expected fwd=%0b cmd=%0b rej=%0b end=%0b addr=%h data=%h",
               tag, fwdStb, cmdStb, rejStb, loadEnd, fwdAddr, fwdData,
               eF, eC, eR, eE, a, d);
    end
  endtask

  task automatic idle(int n, string tagIn);
    for (int i = 0; i < n; i++) step(1'b0, '0, '0, tagIn);
  endtask

  task automatic keys(string tagIn);
    for (int i = 0; i < 3; i++) step(1'b1, KA[i], KD[i], tagIn);
  endtask

  function automatic int pickGap();
    if ($urandom % 10 == 0) return GAP + int'($urandom % 3);
    return int'($urandom % 3);
  endfunction

  initial begin
    #200000;
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    // R1: quiet during reset
    for (int i = 0; i < 3; i++) begin
      wrStb = 1'b1; wrAddr = KA[0]; wrData = KD[0];
      tick();
      nChecks++;
      if (fwdStb || cmdStb || rejStb || loadEnd) begin
        nFails++;
        $display("FAIL R1: got strobes %0b%0b%0b%0b, expected 0000",
                 fwdStb, cmdStb, rejStb, loadEnd);
      end
    end
    wrStb = 1'b0;
    rstN = 1'b1;
    mHold = HOLD; mStep = 0; mGap = 0; mHas = 0;
    // R1: first edge after release, no write
    step(1'b0, '0, '0, "R1");
    // R2: full key sequence plus data during hold gives nothing
    keys("R2");
    step(1'b1, 15'h0123, 8'h44, "R2");
    idle(HOLD - 5, "R2");
    // R2: first evaluated edge: a plain write is rejected
    step(1'b1, 15'h0040, 8'h11, "R2");
    // R3 / R4: unlock, then data including key addresses
    keys("R3");
    step(1'b1, 15'h5555, 8'hAA, "R4");
    step(1'b1, 15'h2AAA, 8'h55, "R4");
    step(1'b1, 15'h1234, 8'h9C, "R4");
    // R7: close exactly GAP+1 edges after the last forwarded write
    idle(GAP, "R7");
    step(1'b0, '0, '0, "R7");
    // R8: no prefix after close
    step(1'b1, 15'h1234, 8'h01, "R8");
    // R5: mismatch at the middle and last steps
    step(1'b1, KA[0], KD[0], "R3");
    step(1'b1, KA[1], 8'h56, "R5");
    step(1'b1, KA[1], KD[1], "R5");
    keys("R3");
    idle(GAP + 2, "R7"); // empty load: no close marker
    step(1'b1, KA[0], KD[0], "R3");
    step(1'b1, KA[1], KD[1], "R3");
    step(1'b1, KA[2], 8'hA1, "R5");
    // R6: gap of exactly GAP continues, GAP+1 restarts
    step(1'b1, KA[0], KD[0], "R6");
    idle(GAP - 1, "R6");
    step(1'b1, KA[1], KD[1], "R6");
    idle(GAP, "R6");
    step(1'b1, KA[2], KD[2], "R6");
    idle(GAP + 1, "R6");
    // random phase
    for (int it = 0; it < 1500; it++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 6) begin
        for (int k = 0; k < 3; k++) begin
          logic [7:0] dd;
          dd = KD[k];
          if ($urandom % 12 == 0) dd = dd ^ 8'h01;
          idle(pickGap(), "");
          step(1'b1, KA[k], dd, "");
        end
        for (int k = 0; k < int'($urandom % 4); k++) begin
          idle(pickGap(), "");
          step(1'b1, 15'($urandom), 8'($urandom), "");
        end
      end else if (r < 9) begin
        step(1'b1, 15'($urandom), 8'($urandom), "");
      end else begin
        idle(int'($urandom % (GAP + 4)), "");
      end
    end
    idle(GAP + 2, "R7");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule